// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block turns a fast reference clock into the 16x oversampling tick that a UART transmitter and receiver share. Each tick lasts a whole number of reference cycles set by an integer divisor. A per-tick fractional pattern can add one more cycle to chosen ticks inside each 16-tick bit period. The average bit length therefore has a resolution of one reference cycle per bit, which is one sixteenth of a tick. A bit-boundary pulse marks the last tick of every bit period.

The settings are loaded through a small write port with four targets. The first is the integer divisor. The second is a 16-bit slot mask, where bit k lengthens tick k. The third is a plain remainder count, which lengthens the first ticks of the bit. The fourth is a helper target that takes the raw clock-to-baud ratio and works out the divisor and an evenly spread mask by itself.

While the block runs, every write is held back until the next bit boundary, so no tick in progress is cut short. While the block is disabled, writes apply at once and the timing state stays cleared.

Top module: `baud_tick_gen`

## Requirements
- R1: In mask mode, a bit period, from its first counted cycle to the cycle that carries its boundary pulse, lasts 16*(D+1) + popcount(M) reference cycles, where D is the divisor and M is the 16-bit mask.
- R2: In mask mode, tick k of a bit period (k = 0..15, counted from the first tick after the boundary) lasts D+1 cycles, plus one cycle when bit k of M is 1 (bit 0 belongs to the first tick).
- R3: A write with wr_sel=3 selects count mode with remainder C = wr_data[3:0]. The first C ticks of each bit last D+2 cycles and the rest last D+1 cycles, so the bit lasts 16*(D+1)+C cycles.
- R4: bit_end is high only in the same cycle as the 16th tick of a bit period. The next tick starts a new period.
- R5: A write made while en is high does not change the current bit period. It applies from the next bit period on, and this includes a write made in the very cycle that bit_end is high.
- R6: While en is low, tick and bit_end stay low and the cycle and tick counters are cleared. A later rise of en starts a complete fresh bit period.
- R7: A write with wr_sel=2 takes a ratio Q (at least 16). It sets D = Q/16 - 1 and selects mask mode, with the mask taken from a spread table indexed by Q mod 16. The table is: 0:0000, 1:0080, 2:0808, 3:0888, 4:2222, 5:4924, 6:4A52, 7:54AA, 8:5555, 9:D555, 10:D5D5, 11:DDD5, 12:DDDD, 13:DFDD, 14:DFDF, 15:FFDF (hex). As a result each bit lasts Q cycles.
- R8: After reset, D=0, the mask is 0, mask mode is selected, and tick and bit_end are low. A write with wr_sel=0 sets D = wr_data[DIV_W-1:0]. A write with wr_sel=1 sets M = wr_data[15:0] and selects mask mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_sel | input | 2 | Write target: 0 divisor, 1 mask, 2 ratio, 3 remainder count |
| wr_data | input | DIV_W+4 | Write data |
| tick | output | 1 | One-cycle oversample tick |
| bit_end | output | 1 | One-cycle pulse on the last tick of each bit period |

## Verification
Two events can land on the same clock edge: a configuration write and the bit boundary that reloads the running settings. The bench provokes this case on purpose. It waits until bit_end is visible, then holds a divisor write in that same cycle. The scoreboard must then see the old length for the bit that is ending and the new length for the very next bit. A second write, made in the middle of a bit, must leave that bit's length unchanged.

// File: rtl/baud_tick_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, write-target and fractional-mode encodings,
// and the even-spread mask table used by the ratio helper.
package baud_tick_pkg;

    localparam int unsigned TICKS_PER_BIT = 16;
    localparam int unsigned IDX_W         = $clog2(TICKS_PER_BIT);

    typedef enum logic [1:0] {
        SEL_DIV   = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_RATIO = 2'd2,
        SEL_COUNT = 2'd3
    } wr_sel_e;

    typedef enum logic {
        FRAC_MASK  = 1'b0,
        FRAC_COUNT = 1'b1
    } frac_mode_e;

    // Maps a remainder of 0..15 to a mask with that many bits set,
    // spread across the bit period instead of packed together.
    function automatic logic [TICKS_PER_BIT-1:0] spread_mask(input logic [IDX_W-1:0] rem);
        logic [TICKS_PER_BIT-1:0] m;
        case (rem)
            4'd0:    m = 16'h0000;
            4'd1:    m = 16'h0080;
            4'd2:    m = 16'h0808;
            4'd3:    m = 16'h0888;
            4'd4:    m = 16'h2222;
            4'd5:    m = 16'h4924;
            4'd6:    m = 16'h4A52;
            4'd7:    m = 16'h54AA;
            4'd8:    m = 16'h5555;
            4'd9:    m = 16'hD555;
            4'd10:   m = 16'hD5D5;
            4'd11:   m = 16'hDDD5;
            4'd12:   m = 16'hDDDD;
            4'd13:   m = 16'hDFDD;
            4'd14:   m = 16'hDFDF;
            default: m = 16'hFFDF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/baud_ratio_split.sv
`timescale 1ns/1ps
// Module: baud_ratio_split
// Splits a clock-to-baud ratio into the integer divisor and a spread mask.
// Assumes the ratio is at least 16, so that the divisor does not wrap.
module baud_ratio_split
    import baud_tick_pkg::*;
#(
    parameter int unsigned DIV_W = 12
) (
    input  logic [DIV_W+IDX_W-1:0]   ratio,
    output logic [DIV_W-1:0]         div_val,
    output logic [TICKS_PER_BIT-1:0] mask_val
);

    // Divisor is the whole-tick part of the ratio, minus one.
    assign div_val  = ratio[DIV_W+IDX_W-1:IDX_W] - DIV_W'(1);
    // The mask comes from the remainder through the spread table.
    assign mask_val = spread_mask(ratio[IDX_W-1:0]);

endmodule

// File: rtl/baud_cfg_regs.sv
`timescale 1ns/1ps
// Module: baud_cfg_regs
// Holds the written settings (shadow) and the settings in use (active).
// The active copy reloads from the next shadow value every cycle while the
// block is disabled, and at the bit-boundary edge while it runs. A write in
// the boundary cycle therefore applies to the following bit.
// Assumes DIV_W+4 >= 16, so that a full mask fits in one write word.
module baud_cfg_regs
    import baud_tick_pkg::*;
#(
    parameter int unsigned DIV_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     bit_end,
    input  logic                     wr_en,
    input  logic [1:0]               wr_sel,
    input  logic [DIV_W+IDX_W-1:0]   wr_data,
    output logic [DIV_W-1:0]         act_div,
    output logic [TICKS_PER_BIT-1:0] act_frac,
    output frac_mode_e               act_mode
);

    logic [DIV_W-1:0]         sh_div,  nxt_div;
    logic [TICKS_PER_BIT-1:0] sh_frac, nxt_frac;
    frac_mode_e               sh_mode, nxt_mode;
    logic [DIV_W-1:0]         split_div;
    logic [TICKS_PER_BIT-1:0] split_mask;

    baud_ratio_split #(.DIV_W(DIV_W)) u_split (
        .ratio    (wr_data),
        .div_val  (split_div),
        .mask_val (split_mask)
    );

    // Next shadow value: the current shadow with this cycle's write merged in.
    always_comb begin
        nxt_div  = sh_div;
        nxt_frac = sh_frac;
        nxt_mode = sh_mode;
        if (wr_en) begin
            case (wr_sel_e'(wr_sel))
                SEL_DIV:   nxt_div = wr_data[DIV_W-1:0];
                SEL_MASK: begin
                    nxt_frac = wr_data[TICKS_PER_BIT-1:0];
                    nxt_mode = FRAC_MASK;
                end
                SEL_RATIO: begin
                    nxt_div  = split_div;
                    nxt_frac = split_mask;
                    nxt_mode = FRAC_MASK;
                end
                default: begin
                    nxt_frac = {{(TICKS_PER_BIT-IDX_W){1'b0}}, wr_data[IDX_W-1:0]};
                    nxt_mode = FRAC_COUNT;
                end
            endcase
        end
    end

    // Shadow registers take every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_div  <= '0;
            sh_frac <= '0;
            sh_mode <= FRAC_MASK;
        end else begin
            sh_div  <= nxt_div;
            sh_frac <= nxt_frac;
            sh_mode <= nxt_mode;
        end
    end

    // Active registers follow the shadow only when idle or at a bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_div  <= '0;
            act_frac <= '0;
            act_mode <= FRAC_MASK;
        end else if (!en || bit_end) begin
            act_div  <= nxt_div;
            act_frac <= nxt_frac;
            act_mode <= nxt_mode;
        end
    end

endmodule

// File: rtl/baud_slot_sel.sv
`timescale 1ns/1ps
// Module: baud_slot_sel
// Decides whether the current tick gets one extra reference cycle. Mask mode
// uses frac[idx]. Count mode builds a thermometer from frac[3:0], so the
// first ticks of the bit are the long ones.
module baud_slot_sel
    import baud_tick_pkg::*;
(
    input  frac_mode_e               mode,
    input  logic [TICKS_PER_BIT-1:0] frac,
    input  logic [IDX_W-1:0]         idx,
    output logic                     extra
);

    logic [TICKS_PER_BIT-1:0] therm;
    logic [TICKS_PER_BIT-1:0] slots;

    // One thermometer bit per tick position: set when the position is below the count.
    for (genvar k = 0; k < TICKS_PER_BIT; k++) begin : g_therm
        assign therm[k] = (IDX_W'(k) < frac[IDX_W-1:0]);
    end

    // Pick the slot vector for the mode, then the bit for this tick.
    assign slots = (mode == FRAC_MASK) ? frac : therm;
    assign extra = slots[idx];

endmodule

// File: rtl/baud_tick_core.sv
`timescale 1ns/1ps
// Module: baud_tick_core
// Counts reference cycles to (div + extra) and then raises tick. It also
// steps the 4-bit tick index, and raises bit_end on index 15. Both counters
// are held at zero while en is low.
module baud_tick_core
    import baud_tick_pkg::*;
#(
    parameter int unsigned DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             extra,
    output logic [IDX_W-1:0] idx,
    output logic             tick,
    output logic             bit_end
);

    localparam int unsigned CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Last count value of this tick: div, or div+1 when the slot is long.
    assign last    = {1'b0, div} + CNT_W'(extra);
    assign tick    = en && (cnt == last);
    assign bit_end = tick && (idx == IDX_W'(TICKS_PER_BIT - 1));

    // Cycle counter and tick index.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
            idx <= '0;
        end else if (tick) begin
            cnt <= '0;
            idx <= idx + IDX_W'(1);
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/baud_tick_gen.sv
`timescale 1ns/1ps
// Module: baud_tick_gen (top)
// Fractional 16x baud tick generator. It has a configuration write port, an
// enable input, and tick and bit-boundary outputs.
// Assumes writes of a ratio below 16 are never made.
module baud_tick_gen
    import baud_tick_pkg::*;
#(
    parameter int unsigned DIV_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   wr_en,
    input  logic [1:0]             wr_sel,
    input  logic [DIV_W+IDX_W-1:0] wr_data,
    output logic                   tick,
    output logic                   bit_end
);

    logic [DIV_W-1:0]         act_div;
    logic [TICKS_PER_BIT-1:0] act_frac;
    frac_mode_e               act_mode;
    logic [IDX_W-1:0]         idx;
    logic                     extra;

    baud_cfg_regs #(.DIV_W(DIV_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .bit_end  (bit_end),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .act_div  (act_div),
        .act_frac (act_frac),
        .act_mode (act_mode)
    );

    baud_slot_sel u_slot (
        .mode  (act_mode),
        .frac  (act_frac),
        .idx   (idx),
        .extra (extra)
    );

    baud_tick_core #(.DIV_W(DIV_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .div     (act_div),
        .extra   (extra),
        .idx     (idx),
        .tick    (tick),
        .bit_end (bit_end)
    );

endmodule

// File: rtl/baud_tick_chk.sv
`timescale 1ns/1ps
// Module: baud_tick_chk
// Property checker bound to baud_tick_gen. It keeps its own count of ticks
// since the last boundary, and watches how the active divisor is reloaded.
module baud_tick_chk #(
    parameter int unsigned DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             tick,
    input logic             bit_end,
    input logic [DIV_W-1:0] act_div
);

    logic [3:0] seen;

    // Ticks seen since the last boundary, or since the block was disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  seen <= '0;
        else if (bit_end)   seen <= '0;
        else if (tick)      seen <= seen + 4'd1;
    end

    // R6: nothing is emitted while disabled.
    p_quiet_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!tick && !bit_end));

    // R4: the boundary pulse only comes with a tick.
    p_edge_with_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |-> tick);

    // R4: the boundary falls on the 16th tick.
    p_sixteenth_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |-> (seen == 4'd15));

    // R4: no 16th tick passes without a boundary pulse.
    p_no_missed_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && seen == 4'd15) |-> bit_end);

    // R5: while running, the divisor in use changes only after a boundary.
    p_hold_mid_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$past(bit_end)) |-> $stable(act_div));

endmodule

bind baud_tick_gen baud_tick_chk #(.DIV_W(DIV_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .tick    (tick),
    .bit_end (bit_end),
    .act_div (act_div)
);

// File: tb/test_baud_tick_gen.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected bit lengths, and a monitor
// measures each bit period and compares it with the queue.
module test_baud_tick_gen;

    localparam int DIV_W = 12;
    localparam int DW    = DIV_W + 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic          tick;
    logic          bit_end;

    int total = 0;
    int bad   = 0;
    int exp_q[$];
    int gaps[16];
    int bit_cnt = 0;
    int tick_cnt = 0;
    int tidx = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    baud_tick_gen #(.DIV_W(DIV_W)) i_baud_tick_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .tick    (tick),
        .bit_end (bit_end)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One write, driven just after a rising edge.
    task automatic wr(input logic [1:0] sel, input int data);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = DW'(data);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Queue nbits bits of length e, run until they are all seen, then stop.
    task automatic run_bits(input int e, input int nbits, input string req);
        cur_req = req;
        for (int i = 0; i < nbits; i++) exp_q.push_back(e);
        @(posedge clk); #1; en = 1'b1;
        while (exp_q.size() != 0) begin @(posedge clk); #1; end
        en = 1'b0;
        @(posedge clk); #1;
    endtask

    // Compare the tick lengths of the last bit with D+1 plus the slot bit.
    task automatic chk_gaps(input string req, input int d, input logic [15:0] slots);
        for (int k = 0; k < 16; k++)
            check(gaps[k] == d + 1 + int'(slots[k]), req, gaps[k], d + 1 + int'(slots[k]), $sformatf("tick %0d length", k));
    endtask

    // Monitor: measures tick and bit lengths at the falling edge.
    always @(negedge clk) begin
        if (!rst_n || !en) begin
            bit_cnt = 0; tick_cnt = 0; tidx = 0;
        end else begin
            bit_cnt++;
            tick_cnt++;
            if (tick) begin
                gaps[tidx] = tick_cnt;
                tick_cnt = 0;
                tidx = (tidx + 1) % 16;
            end
            if (bit_end) begin
                check(tidx == 0, "R4", tidx, 0, "boundary on 16th tick");
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", bit_cnt, -1, "unexpected bit boundary");
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(bit_cnt == e, cur_req, bit_cnt, e, "bit length");
                end
                bit_cnt = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        logic [15:0] m;
        repeat (4) @(posedge clk);
        #1;
        // R8: reset state, then default divisor 0 with no mask gives 16-cycle bits.
        check(tick == 1'b0, "R8", tick, 0, "tick after reset");
        check(bit_end == 1'b0, "R8", bit_end, 0, "bit_end after reset");
        rst_n = 1'b1;
        run_bits(16, 2, "R8");

        // R6: disabled, with a nonzero divisor, emits no ticks.
        wr(2'd0, 2);
        cnt = 0;
        for (int i = 0; i < 100; i++) begin @(posedge clk); #1; if (tick || bit_end) cnt++; end
        check(cnt == 0, "R6", cnt, 0, "pulses while disabled");

        // R1/R2: mask mode with divisor 3 and varied masks.
        wr(2'd0, 3);
        for (int r = 0; r < 16; r++) begin
            m = 16'((32'h1 << r) - 1) ^ 16'(r * 16'h0911);
            wr(2'd1, int'(m));
            run_bits(64 + $countones(m), 2, "R1");
            if (r == 5 || r == 11) chk_gaps("R2", 3, m);
        end

        // R3: count mode, where the first C ticks are long.
        for (int c = 0; c < 16; c++) begin
            wr(2'd3, c);
            run_bits(64 + c, 2, "R3");
            if (c == 0 || c == 7 || c == 15) chk_gaps("R3", 3, 16'((32'h1 << c) - 1));
        end

        // R7: the ratio helper gives a bit length equal to the ratio.
        for (int r = 0; r < 16; r++) begin
            wr(2'd2, 80 + r);
            run_bits(80 + r, 2, "R7");
            if (r == 2)  chk_gaps("R7", 4, 16'h0808);
            if (r == 8)  chk_gaps("R7", 4, 16'h5555);
            if (r == 15) chk_gaps("R7", 4, 16'hFFDF);
        end

        // R5: a write in the middle of a bit applies from the next bit on.
        wr(2'd0, 3);
        wr(2'd1, 0);
        cur_req = "R5";
        exp_q.push_back(64); exp_q.push_back(96);
        @(posedge clk); #1; en = 1'b1;
        repeat (10) begin @(posedge clk); #1; end
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = DW'(5);
        @(posedge clk); #1; wr_en = 1'b0;
        while (exp_q.size() != 0) begin @(posedge clk); #1; end
        en = 1'b0;
        @(posedge clk); #1;

        // R5: a write made in the bit_end cycle applies to the very next bit.
        wr(2'd0, 3);
        exp_q.push_back(64); exp_q.push_back(96);
        @(posedge clk); #1; en = 1'b1;
        do begin @(posedge clk); #1; end while (!bit_end);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = DW'(5);
        @(posedge clk); #1; wr_en = 1'b0;
        while (exp_q.size() != 0) begin @(posedge clk); #1; end
        en = 1'b0;
        @(posedge clk); #1;

        // R6: dropping en in the middle of a bit restarts a full fresh bit.
        wr(2'd0, 3);
        cur_req = "R6";
        exp_q.push_back(64);
        @(posedge clk); #1; en = 1'b1;
        repeat (20) begin @(posedge clk); #1; end
        en = 1'b0;
        repeat (5) begin @(posedge clk); #1; end
        check(exp_q.size() == 1, "R6", exp_q.size(), 1, "no boundary from a partial bit");
        en = 1'b1;
        while (exp_q.size() != 0) begin @(posedge clk); #1; end
        en = 1'b0;
        repeat (3) @(posedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule